// File: doc/BRIEF.md
# Serial Daisy-Chain Switch Control Register

This block is the serial configuration path of a four-switch analog multiplexer controller. A host frames each transfer by pulling an active-low select line low. It then clocks control bits into a short shift register on the rising edges of a serial clock. The word is committed to a set of control latches when select returns high. The committed word is decoded into one enable line per switch, with either a single four-way selection or two ganged two-way selections. The last stage of the shift register is brought out as a serial data output, so several controllers can share one select line and pass bits down a chain.

Every input is sampled by a fast system clock. The serial clock, select and data lines pass through two-stage synchronisers, and their edges are detected in the system clock domain. The system clock must run at least four times faster than the serial clock. A separate active-low configuration reset returns the controller to its power-on word. An enable input can force every switch off at any time without disturbing the stored word.

Top module: `sw_serial_ctrl`

## Requirements
- R1: On each serial-clock rising edge while select is low and serial mode is on, the data bit enters the shift register. The first bit of a frame is the low address bit A0, the second is A1, the third is a spare bit, and the fourth is the disable bit, which ends in bit 3 (the MSB) of the word.
- R2: While select is high, serial-clock edges do not change the shift register or the serial data output.
- R3: The serial data output is bit 0 of the shift register, which is the fourth stage. It presents the data bit shifted in four serial clocks earlier. It reads 0 whenever serial mode is off.
- R4: The control latches load the shift register only on a rising edge of select. During a frame the switch outputs keep the previously latched word.
- R5: When a frame holds more than four bits, only the last four clocked bits take effect.
- R6: Driving the configuration reset low loads the shift register and the latches with the power-on word (A0=0, A1=0, disable=1), so every switch is off and the serial data output reads 0.
- R7: Enable low forces every switch output to 0 within one system clock without changing the latched word. When enable returns high, the previous selection is restored.
- R8: In four-channel mode (mode_4ch=1) with disable=0, the A1:A0 values 00, 01, 10 and 11 enable switch output bit 0, 1, 2 and 3 respectively. Exactly one switch is on.
- R9: In dual two-channel mode (mode_4ch=0) with disable=0, A0=0 enables output bits 0 and 2, and A0=1 enables output bits 1 and 3.
- R10: With disable=1 in the latched word, every switch output is 0 in either mode.
- R11: Switch outputs are registered and read 0 during system reset and for at least one system clock after its release.
- R12: With serial mode off, the serial clock and select lines change neither the shift register nor the latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples every input |
| rst | input | 1 | Synchronous active-high system reset |
| ser_mode | input | 1 | 1 selects the serial interface and drives the serial data output |
| mode_4ch | input | 1 | 1 = single four-way decode, 0 = dual two-way decode |
| cfg_rst_n | input | 1 | Active-low configuration reset to the power-on word |
| en | input | 1 | Switch enable; 0 forces all switches off |
| sclk | input | 1 | Serial shift clock, asynchronous |
| cs_n | input | 1 | Active-low frame select, asynchronous |
| din | input | 1 | Serial data in, sampled on serial-clock rising edges |
| dout | output | 1 | Fourth shift stage, for cascading |
| sw_on | output | 4 | One enable per switch, bit 0 = switch 1 |

## Verification
The hardest state to reach from the ports is a shift register that holds a different word from the latches, and then proving that this word is never committed by stray serial clocks. It must be committed only by a later select edge with no clocks in between. The stimulus reaches this state with random frames of zero to nine bits. These are interleaved with bursts of serial clocks while select is high and with frames sent while serial mode is off. A bench model tracks both the shift register and the latch, so every following bare select pulse and every tap of the serial output exposes any stray shift.

// File: rtl/sw_ctrl_pkg.sv
package sw_ctrl_pkg;
  // Number of switches and derived word layout: address bits, spare bits, disable bit on top.
  localparam int unsigned NUM_SW   = 4;
  localparam int unsigned ADDR_W   = $clog2(NUM_SW);
  localparam int unsigned SPARE_W  = 1;
  localparam int unsigned CTRL_W   = ADDR_W + SPARE_W + 1;
  localparam int unsigned DIS_POS  = CTRL_W - 1;

  // Power-on word: address zero, disable set.
  localparam logic [CTRL_W-1:0] POR_WORD = {1'b1, {(CTRL_W-1){1'b0}}};

  typedef enum logic {
    DEC_DUAL = 1'b0,
    DEC_QUAD = 1'b1
  } dec_mode_e;
endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
  parameter int unsigned          W        = 4,
  parameter logic [W-1:0]         INIT_VAL = '0
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] word,
  output logic         tail
);
  // New bits enter at the top and walk toward bit 0, so the first bit of a
  // four-bit frame lands in bit 0 and the last in the MSB.
  logic [W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (clr)        stage_q <= INIT_VAL;
    else if (shift) stage_q <= {bit_in, stage_q[W-1:1]};
  end

  assign word = stage_q;
  assign tail = stage_q[0];
endmodule

// File: rtl/sw_decode.sv
module sw_decode #(
  parameter int unsigned N_SW = 4,
  parameter int unsigned AW   = $clog2(N_SW)
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            load,
  input  logic            dis_in,
  input  logic [AW-1:0]   addr_in,
  input  logic            quad_mode,
  input  logic            en,
  output logic            dis_q,
  output logic [AW-1:0]   addr_q,
  output logic [N_SW-1:0] sw_q
);
  logic [N_SW-1:0] sel;

  always_ff @(posedge clk) begin
    if (clr) begin
      dis_q  <= 1'b1;
      addr_q <= '0;
    end else if (load) begin
      dis_q  <= dis_in;
      addr_q <= addr_in;
    end
  end

  generate
    for (genvar i = 0; i < N_SW; i++) begin : g_sel
      localparam logic [AW-1:0] IDX = AW'(i);
      always_comb begin
        if (dis_q)          sel[i] = 1'b0;
        else if (quad_mode) sel[i] = (addr_q == IDX);
        else                sel[i] = (addr_q[0] == IDX[0]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr || !en) sw_q <= '0;
    else            sw_q <= sel;
  end
endmodule

// File: rtl/sw_serial_ctrl.sv
module sw_serial_ctrl
  import sw_ctrl_pkg::*;
#(
  parameter int unsigned N_SW        = NUM_SW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ser_mode,
  input  logic            mode_4ch,
  input  logic            cfg_rst_n,
  input  logic            en,
  input  logic            sclk,
  input  logic            cs_n,
  input  logic            din,
  output logic            dout,
  output logic [N_SW-1:0] sw_on
);
  localparam int unsigned AW     = $clog2(N_SW);
  localparam int unsigned WORD_W = AW + SPARE_W + 1;
  localparam logic [WORD_W-1:0] INIT_WORD = {1'b1, {(WORD_W-1){1'b0}}};

  logic clr;
  logic sclk_s, cs_s, din_s;
  logic sclk_prev, cs_prev;
  logic sclk_rise, cs_rise, cs_low;
  logic do_shift, do_load;
  logic [WORD_W-1:0] sr_q;
  logic sr_tail;
  logic dis_q;
  logic [AW-1:0] addr_q;
  logic dout_q;
  dec_mode_e dmode;

  assign clr = rst | ~cfg_rst_n;

  cdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst(rst), .d(sclk), .q(sclk_s));
  cdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst(rst), .d(cs_n), .q(cs_s));
  cdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
    .clk(clk), .rst(rst), .d(din), .q(din_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      cs_prev   <= 1'b1;
    end else begin
      sclk_prev <= sclk_s;
      cs_prev   <= cs_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign cs_rise   = cs_s & ~cs_prev;
  assign cs_low    = ~cs_s;
  assign do_shift  = ser_mode & cs_low & sclk_rise;
  assign do_load   = ser_mode & cs_rise;
  assign dmode     = mode_4ch ? DEC_QUAD : DEC_DUAL;

  shift_chain #(.W(WORD_W), .INIT_VAL(INIT_WORD)) u_shift (
    .clk(clk), .clr(clr), .shift(do_shift), .bit_in(din_s),
    .word(sr_q), .tail(sr_tail));

  sw_decode #(.N_SW(N_SW), .AW(AW)) u_dec (
    .clk(clk), .clr(clr), .load(do_load),
    .dis_in(sr_q[WORD_W-1]), .addr_in(sr_q[AW-1:0]),
    .quad_mode(dmode == DEC_QUAD), .en(en),
    .dis_q(dis_q), .addr_q(addr_q), .sw_q(sw_on));

  always_ff @(posedge clk) begin
    if (clr) dout_q <= 1'b0;
    else     dout_q <= ser_mode & sr_tail;
  end

  assign dout = dout_q;
endmodule

// File: rtl/sw_serial_ctrl_chk.sv
module sw_serial_ctrl_chk #(
  parameter int unsigned N_SW   = 4,
  parameter int unsigned AW     = 2,
  parameter int unsigned WORD_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_rst_n,
  input logic              en,
  input logic              ser_mode,
  input logic              mode_4ch,
  input logic              dout,
  input logic [N_SW-1:0]   sw_on,
  input logic              cs_rise,
  input logic              cs_low,
  input logic              sclk_rise,
  input logic [WORD_W-1:0] sr_q,
  input logic              dis_q,
  input logic [AW-1:0]     addr_q
);
  // R6
  cfg_reset_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_rst_n |=> (sw_on == '0));

  // R7
  enable_override_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (sw_on == '0));

  // R8
  quad_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_4ch && $past(mode_4ch)) |-> $onehot0(sw_on));

  // R9
  dual_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_4ch && $past(!mode_4ch)) |->
      ($countones(sw_on) == 0 || $countones(sw_on) == N_SW/2));

  // R3
  dout_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ser_mode |=> !dout);

  // R4
  latch_on_cs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable({dis_q, addr_q}) && $past(cfg_rst_n) && !$past(rst))
      |-> $past(cs_rise && ser_mode));

  // R2
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!(sclk_rise && cs_low && ser_mode)) && $past(cfg_rst_n) && !$past(rst))
      |-> $stable(sr_q));

  // R11
  post_reset_off_chk: assert property (@(posedge clk)
    $past(rst) |-> (sw_on == '0));
endmodule

bind sw_serial_ctrl sw_serial_ctrl_chk #(
  .N_SW(N_SW), .AW(AW), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_rst_n(cfg_rst_n), .en(en),
  .ser_mode(ser_mode), .mode_4ch(mode_4ch), .dout(dout), .sw_on(sw_on),
  .cs_rise(cs_rise), .cs_low(cs_low), .sclk_rise(sclk_rise),
  .sr_q(sr_q), .dis_q(dis_q), .addr_q(addr_q)
);

// File: tb/sw_serial_ctrl_bench.sv
module sw_serial_ctrl_bench;
  logic clk = 1'b0;
  logic rst, ser_mode, mode_4ch, cfg_rst_n, en, sclk, cs_n, din;
  logic dout;
  logic [3:0] sw_on;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Bench model of the shift register and latch.
  logic [3:0] m_sr;
  logic       m_dis;
  logic [1:0] m_addr;

  always #4 clk = ~clk;

  sw_serial_ctrl u_sw_serial_ctrl (
    .clk(clk), .rst(rst), .ser_mode(ser_mode), .mode_4ch(mode_4ch),
    .cfg_rst_n(cfg_rst_n), .en(en), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .sw_on(sw_on));

  function automatic logic [3:0] exp_sw(logic dis, logic [1:0] addr, logic m4, logic e);
    logic [3:0] r;
    r = '0;
    if (!dis && e) begin
      if (m4) r[addr] = 1'b1;
      else    r = addr[0] ? 4'b1010 : 4'b0101;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_sw(input string tag);
    chk(tag, {28'd0, sw_on}, {28'd0, exp_sw(m_dis, m_addr, mode_4ch, en)});
  endtask

  // One serial bit: data set up, rising edge, hold, falling edge.
  task automatic sbit(input logic b);
    din = b;
    cyc(6);
    sclk = 1'b1;
    if (!cs_n && ser_mode) m_sr = {b, m_sr[3:1]};
    cyc(6);
    // R3: tap shows the fourth stage once the edge has propagated
    chk("R3 dout tap", {31'd0, dout}, {31'd0, ser_mode & m_sr[0]});
    sclk = 1'b0;
  endtask

  task automatic frame(input logic [15:0] bits, input int n);
    cs_n = 1'b0;
    cyc(6);
    for (int i = 0; i < n; i++) begin
      sbit(bits[i]);
      // R4: no change mid-frame
      if (i == 1) chk_sw("R4 mid-frame hold");
    end
    cyc(6);
    cs_n = 1'b1;
    if (ser_mode) begin m_dis = m_sr[3]; m_addr = m_sr[1:0]; end
    cyc(8);
  endtask

  function automatic logic [15:0] word(input logic dis, input logic [1:0] a);
    return {12'd0, dis, 1'b0, a};
  endfunction

  task automatic cfg_reset();
    cfg_rst_n = 1'b0;
    cyc(2);
    m_sr = 4'b1000; m_dis = 1'b1; m_addr = 2'b00;
    chk("R6 cfg reset off", {28'd0, sw_on}, 32'd0);
    chk("R6 cfg reset dout", {31'd0, dout}, 32'd0);
    cfg_rst_n = 1'b1;
    cyc(2);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst = 1'b1; ser_mode = 1'b1; mode_4ch = 1'b1; cfg_rst_n = 1'b1;
    en = 1'b1; sclk = 1'b0; cs_n = 1'b1; din = 1'b0;
    m_sr = 4'b1000; m_dis = 1'b1; m_addr = 2'b00;
    cyc(5);
    chk("R11 reset outputs", {28'd0, sw_on}, 32'd0);
    rst = 1'b0;
    cyc(1);
    chk("R11 after release", {28'd0, sw_on}, 32'd0);
    chk("R6 por dout", {31'd0, dout}, 32'd0);

    // R6: bare select pulse after reset commits the power-on word
    frame(16'd0, 0);
    chk("R6 por word off", {28'd0, sw_on}, 32'd0);

    // R1 R8: each address in four-channel mode
    for (int a = 0; a < 4; a++) begin
      frame(word(1'b0, 2'(a)), 4);
      chk("R8 quad decode", {28'd0, sw_on}, {28'd0, 4'(1 << a)});
    end
    // R9: dual mode both halves
    mode_4ch = 1'b0;
    frame(word(1'b0, 2'b10), 4);
    chk("R9 dual a0=0", {28'd0, sw_on}, 32'h5);
    frame(word(1'b0, 2'b01), 4);
    chk("R9 dual a0=1", {28'd0, sw_on}, 32'ha);
    // R10: disable bit in both modes
    frame(word(1'b1, 2'b01), 4);
    chk("R10 disable dual", {28'd0, sw_on}, 32'h0);
    mode_4ch = 1'b1;
    cyc(2);
    chk("R10 disable quad", {28'd0, sw_on}, 32'h0);

    // R5: eight bits, last four select address 3
    frame({8'd0, word(1'b0, 2'b11)[3:0], word(1'b1, 2'b00)[3:0]}, 8);
    chk("R5 last four win", {28'd0, sw_on}, 32'h8);

    // R7: enable override and restore
    en = 1'b0;
    cyc(2);
    chk("R7 enable low", {28'd0, sw_on}, 32'h0);
    en = 1'b1;
    cyc(2);
    chk("R7 enable restore", {28'd0, sw_on}, 32'h8);

    // R2: serial clocks with select high are ignored
    frame(word(1'b0, 2'b01), 4);
    for (int i = 0; i < 4; i++) sbit(1'b0);
    frame(16'd0, 0);
    chk("R2 ignored clocks", {28'd0, sw_on}, 32'h2);

    // R12: serial mode off freezes everything
    ser_mode = 1'b0;
    frame(word(1'b0, 2'b11), 4);
    chk("R12 frozen latch", {28'd0, sw_on}, 32'h2);
    chk("R3 dout idle", {31'd0, dout}, 32'd0);
    ser_mode = 1'b1;
    cyc(4);
    frame(16'd0, 0);
    chk("R12 shift untouched", {28'd0, sw_on}, 32'h2);

    cfg_reset();

    // Random mix
    for (int it = 0; it < 300; it++) begin
      int unsigned act;
      act = $urandom_range(0, 9);
      mode_4ch = 1'($urandom_range(0, 1));
      en = ($urandom_range(0, 4) != 0);
      if (act == 7) cfg_reset();
      else if (act == 8) begin
        ser_mode = 1'b0;
        frame(16'($urandom), $urandom_range(0, 6));
        ser_mode = 1'b1;
        cyc(4);
      end else if (act == 9) begin
        for (int i = 0; i < 3; i++) sbit(1'($urandom));
      end else begin
        frame(16'($urandom), $urandom_range(0, 9));
      end
      chk_sw("R1 random frame");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule